// File: doc/BRIEF.md
# Receive Buffer with Hysteretic Modem Handshake

This block is the receive-side store and the hardware handshake logic of one serial channel. The receiver deposits each completed character, together with its three error bits, into a first-in first-out buffer. The host drains the buffer through a read port. The block reports the fill level and a receive-data interrupt that fires once the fill reaches a programmable trigger.

The block drives two active-low request pins, `rts_n` and `dtr_n`. A pair-select bit chooses which of them is under automatic control. When the fill climbs to the trigger plus a hysteresis amount, the selected pin is pulled high to ask the far end to pause. It is lowered again only once the fill has fallen to the trigger minus the hysteresis.

On the input side, the selected active-low clear pin (`cts_n` or `dsr_n`) is synchronised. When it is high, the local transmitter's permission is withdrawn. The permission output only changes between characters, so a character already on the line always completes.

Top module: `rxflow_ctrl`

## Requirements
- R1: Entries come out in the order written, with each 8-bit data byte paired with the 3 error bits written with it. `rd_data`/`rd_err` update on the clock edge that accepts `rd_en`. A read while the buffer is empty changes nothing.
- R2: With `fifo_en`=1 the buffer holds up to 64 entries. `fill` reports the current count.
- R3: With `fifo_en`=0 the buffer holds at most 1 entry, and the interrupt trigger is taken as 1 whatever `trig_lvl` holds.
- R4: A write while the buffer is at capacity is discarded, leaving `fill` and the stored entries unchanged, and sets the sticky flag `ovr`. A pulse on `stat_rd` clears `ovr`.
- R5: `rx_irq` is 1 exactly when the fill is at or above the effective trigger, valid in the same cycle as `fill`. A `trig_lvl` of 0 is taken as 1.
- R6: Under automatic output control, the selected request pin goes high when the fill reaches `trig_lvl`+`hyst_lvl`. It stays high until the fill falls to `trig_lvl`-`hyst_lvl` (floored at 0), when it goes low again.
- R7: Under automatic output control, the selected request pin is low only while its MCR bit (`mcr_rts` for RTS, `mcr_dtr` for DTR) is 1. With that bit 0 the pin stays high at any fill.
- R8: With `auto_out`=0, each request pin is the inverse of its MCR bit, one cycle after the change, regardless of fill.
- R9: `pair_sel`=0 puts `rts_n`/`cts_n` under automatic control and `pair_sel`=1 puts `dtr_n`/`dsr_n` under it. The request pin that is not selected follows the inverse of its own MCR bit.
- R10: With `auto_in`=1, `tx_allow` goes to 0 while the selected clear pin is high and back to 1 when it is low, within SYNC_STAGES+1 cycles. The unselected clear pin has no effect. With `auto_in`=0, `tx_allow` is 1.
- R11: `tx_allow` does not change while `tx_busy` is 1. A pending change takes effect once `tx_busy` returns to 0.
- R12: After reset: `fill`=0, `rx_irq`=0, `ovr`=0, `rts_n`=1, `dtr_n`=1 (MCR bits 0), `tx_allow`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | 1: 64-entry buffer, 0: single holding entry |
| pair_sel | input | 1 | 0: RTS/CTS pair automatic, 1: DTR/DSR pair automatic |
| auto_in | input | 1 | Enable clear-pin gating of the transmitter |
| auto_out | input | 1 | Enable fill-driven request pin |
| mcr_rts | input | 1 | Host request bit for RTS |
| mcr_dtr | input | 1 | Host request bit for DTR |
| trig_lvl | input | 7 | Receive trigger level |
| hyst_lvl | input | 7 | Hysteresis amount around the trigger |
| wr_en | input | 1 | Receiver writes a character |
| wr_data | input | 8 | Received data byte |
| wr_err | input | 3 | Error bits of the character |
| rd_en | input | 1 | Host reads one entry |
| rd_data | output | 8 | Data byte of the entry read |
| rd_err | output | 3 | Error bits of the entry read |
| stat_rd | input | 1 | Host status read, clears overrun |
| ovr | output | 1 | Sticky overrun flag |
| fill | output | 7 | Current buffer fill |
| rx_irq | output | 1 | Receive-data interrupt |
| rts_n | output | 1 | Active-low RTS request pin |
| dtr_n | output | 1 | Active-low DTR request pin |
| cts_n | input | 1 | Active-low CTS clear pin (asynchronous) |
| dsr_n | input | 1 | Active-low DSR clear pin (asynchronous) |
| tx_busy | input | 1 | Transmitter is mid-character |
| tx_allow | output | 1 | Transmitter may start a new character |

## Verification
The assertions take for granted that the control bits, trigger and hysteresis hold steady across the cycles in which a threshold is crossed. They also assume `fifo_en` is only cleared while the fill is 0 or 1. The bench changes every control field only at quiet points with the buffer drained, and drives all inputs half a period away from the sampling edge. The clear pins are the only asynchronous inputs, and the bench waits out their synchroniser before it samples `tx_allow`.

// File: rtl/rxflow_pkg.sv
package rxflow_pkg;
  localparam int unsigned RXF_DATA_W = 8;
  localparam int unsigned RXF_ERR_W  = 3;

  typedef struct packed {
    logic [RXF_ERR_W-1:0]  err;
    logic [RXF_DATA_W-1:0] data;
  } rxf_entry_t;

  typedef enum logic {
    PAIR_RTS_CTS = 1'b0,
    PAIR_DTR_DSR = 1'b1
  } pair_sel_e;
endpackage

// File: rtl/rxflow_fifo.sv
module rxflow_fifo
  import rxflow_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fifo_en,
  input  logic             wr_en,
  input  rxf_entry_t       wr_ent,
  input  logic             rd_en,
  input  logic             stat_rd,
  output rxf_entry_t       rd_ent,
  output logic [CNT_W-1:0] fill_q,
  output logic [CNT_W-1:0] fill_nxt,
  output logic             ovr_q
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  rxf_entry_t       mem [DEPTH];
  logic [PTR_W-1:0] wptr_q, rptr_q;
  logic [CNT_W-1:0] cap;
  logic             wr_ok, rd_ok, wr_drop;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  // Capacity shrinks to one holding entry when the buffer is off.
  assign cap     = fifo_en ? CNT_W'(DEPTH) : CNT_W'(1);
  assign wr_ok   = wr_en && (fill_q < cap);
  assign wr_drop = wr_en && (fill_q >= cap);
  assign rd_ok   = rd_en && (fill_q != '0);

  always_comb begin
    fill_nxt = fill_q;
    case ({wr_ok, rd_ok})
      2'b10:   fill_nxt = fill_q + 1'b1;
      2'b01:   fill_nxt = fill_q - 1'b1;
      default: fill_nxt = fill_q;
    endcase
  end

  // Storage without reset, registered read port: maps onto block RAM.
  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr_q] <= wr_ent;
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_ent <= '0;
    else if (rd_ok) rd_ent <= mem[rptr_q];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_q <= '0;
      rptr_q <= '0;
      fill_q <= '0;
    end else begin
      if (wr_ok) wptr_q <= ptr_inc(wptr_q);
      if (rd_ok) rptr_q <= ptr_inc(rptr_q);
      fill_q <= fill_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          ovr_q <= 1'b0;
    else if (wr_drop) ovr_q <= 1'b1;
    else if (stat_rd) ovr_q <= 1'b0;
  end

  // R2
  fill_max_chk: assert property (@(posedge clk) disable iff (rst)
    fill_q <= CNT_W'(DEPTH));

  // R4
  drop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !rd_en && fill_q == cap) |=> (fill_q == $past(fill_q)));

  // R4
  drop_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && fill_q >= cap) |=> ovr_q);

  // R1
  rd_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && fill_q == '0) |=> $stable(rd_ent));
endmodule

// File: rtl/rxflow_req.sv
module rxflow_req
  import rxflow_pkg::*;
#(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] fill_nxt,
  input  logic [CNT_W-1:0] trig_lvl,
  input  logic [CNT_W-1:0] hyst_lvl,
  input  logic             auto_out,
  input  pair_sel_e        pair_sel,
  input  logic             mcr_rts,
  input  logic             mcr_dtr,
  output logic             rts_n,
  output logic             dtr_n
);
  logic [CNT_W:0] thr_hi, thr_lo, fill_w;
  logic           blk_q, blk_nxt;
  logic           auto_rts, auto_dtr;

  // One extra bit keeps trigger plus hysteresis from wrapping.
  assign fill_w = {1'b0, fill_nxt};
  assign thr_hi = {1'b0, trig_lvl} + {1'b0, hyst_lvl};
  assign thr_lo = (trig_lvl >= hyst_lvl) ? {1'b0, trig_lvl - hyst_lvl} : '0;

  always_comb begin
    blk_nxt = blk_q;
    if (fill_w >= thr_hi)      blk_nxt = 1'b1;
    else if (fill_w <= thr_lo) blk_nxt = 1'b0;
  end

  assign auto_rts = auto_out && (pair_sel == PAIR_RTS_CTS);
  assign auto_dtr = auto_out && (pair_sel == PAIR_DTR_DSR);

  always_ff @(posedge clk) begin
    if (rst) begin
      blk_q <= 1'b0;
      rts_n <= 1'b1;
      dtr_n <= 1'b1;
    end else begin
      blk_q <= blk_nxt;
      rts_n <= !(mcr_rts && !(auto_rts && blk_nxt));
      dtr_n <= !(mcr_dtr && !(auto_dtr && blk_nxt));
    end
  end

  // R6
  blk_set_chk: assert property (@(posedge clk) disable iff (rst)
    (blk_q && !$past(blk_q)) |-> $past(fill_w >= thr_hi));

  // R8
  rts_manual_chk: assert property (@(posedge clk) disable iff (rst)
    (!auto_out || pair_sel == PAIR_DTR_DSR) |=> (rts_n == !$past(mcr_rts)));

  // R7
  dtr_off_chk: assert property (@(posedge clk) disable iff (rst)
    !mcr_dtr |=> dtr_n);
endmodule

// File: rtl/rxflow_txgate.sv
module rxflow_txgate
  import rxflow_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      cts_n,
  input  logic      dsr_n,
  input  pair_sel_e pair_sel,
  input  logic      auto_in,
  input  logic      tx_busy,
  output logic      tx_allow
);
  logic [SYNC_STAGES-1:0] cts_sr, dsr_sr;
  logic                   cts_s, dsr_s, clr_hi;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (rst) begin
          cts_sr <= '0;
          dsr_sr <= '0;
        end else begin
          cts_sr <= cts_n;
          dsr_sr <= dsr_n;
        end
      end
    end else begin : g_syncn
      always_ff @(posedge clk) begin
        if (rst) begin
          cts_sr <= '0;
          dsr_sr <= '0;
        end else begin
          cts_sr <= {cts_sr[SYNC_STAGES-2:0], cts_n};
          dsr_sr <= {dsr_sr[SYNC_STAGES-2:0], dsr_n};
        end
      end
    end
  endgenerate

  assign cts_s  = cts_sr[SYNC_STAGES-1];
  assign dsr_s  = dsr_sr[SYNC_STAGES-1];
  assign clr_hi = (pair_sel == PAIR_DTR_DSR) ? dsr_s : cts_s;

  // Permission moves only between characters.
  always_ff @(posedge clk) begin
    if (rst)           tx_allow <= 1'b1;
    else if (!tx_busy) tx_allow <= !(auto_in && clr_hi);
  end

  // R11
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    tx_busy |=> $stable(tx_allow));

  // R10
  gate_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!auto_in && !tx_busy) |=> tx_allow);
endmodule

// File: rtl/rxflow_ctrl.sv
module rxflow_ctrl
  import rxflow_pkg::*;
#(
  parameter int unsigned DEPTH       = 64,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CNT_W       = $clog2(DEPTH) + 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  fifo_en,
  input  logic                  pair_sel,
  input  logic                  auto_in,
  input  logic                  auto_out,
  input  logic                  mcr_rts,
  input  logic                  mcr_dtr,
  input  logic [CNT_W-1:0]      trig_lvl,
  input  logic [CNT_W-1:0]      hyst_lvl,
  input  logic                  wr_en,
  input  logic [RXF_DATA_W-1:0] wr_data,
  input  logic [RXF_ERR_W-1:0]  wr_err,
  input  logic                  rd_en,
  output logic [RXF_DATA_W-1:0] rd_data,
  output logic [RXF_ERR_W-1:0]  rd_err,
  input  logic                  stat_rd,
  output logic                  ovr,
  output logic [CNT_W-1:0]      fill,
  output logic                  rx_irq,
  output logic                  rts_n,
  output logic                  dtr_n,
  input  logic                  cts_n,
  input  logic                  dsr_n,
  input  logic                  tx_busy,
  output logic                  tx_allow
);
  rxf_entry_t       wr_ent, rd_ent;
  logic [CNT_W-1:0] fill_nxt, eff_trig;
  pair_sel_e        pair_e;

  assign wr_ent  = '{err: wr_err, data: wr_data};
  assign rd_data = rd_ent.data;
  assign rd_err  = rd_ent.err;
  assign pair_e  = pair_sel_e'(pair_sel);

  rxflow_fifo #(.DEPTH(DEPTH), .CNT_W(CNT_W)) fifo_i (
    .clk(clk), .rst(rst), .fifo_en(fifo_en),
    .wr_en(wr_en), .wr_ent(wr_ent), .rd_en(rd_en), .stat_rd(stat_rd),
    .rd_ent(rd_ent), .fill_q(fill), .fill_nxt(fill_nxt), .ovr_q(ovr)
  );

  rxflow_req #(.CNT_W(CNT_W)) req_i (
    .clk(clk), .rst(rst), .fill_nxt(fill_nxt),
    .trig_lvl(trig_lvl), .hyst_lvl(hyst_lvl),
    .auto_out(auto_out), .pair_sel(pair_e),
    .mcr_rts(mcr_rts), .mcr_dtr(mcr_dtr),
    .rts_n(rts_n), .dtr_n(dtr_n)
  );

  rxflow_txgate #(.SYNC_STAGES(SYNC_STAGES)) gate_i (
    .clk(clk), .rst(rst), .cts_n(cts_n), .dsr_n(dsr_n),
    .pair_sel(pair_e), .auto_in(auto_in), .tx_busy(tx_busy),
    .tx_allow(tx_allow)
  );

  // Trigger is forced to one entry when the buffer is off or zero is programmed.
  assign eff_trig = (!fifo_en || trig_lvl == '0) ? CNT_W'(1) : trig_lvl;

  always_ff @(posedge clk) begin
    if (rst) rx_irq <= 1'b0;
    else     rx_irq <= (fill_nxt >= eff_trig);
  end

  // R3
  nofifo_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (!fifo_en && fill <= CNT_W'(1)) |=> (fill <= CNT_W'(1)));

  // R5
  irq_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (fill == '0) |-> !rx_irq);
endmodule

// File: tb/rxflow_ctrl_tb.sv
module rxflow_ctrl_tb_top;
  localparam int CNT_W = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fifo_en = 1'b1, pair_sel = 1'b0, auto_in = 1'b0, auto_out = 1'b0;
  logic mcr_rts = 1'b0, mcr_dtr = 1'b0;
  logic [CNT_W-1:0] trig_lvl = 7'd1, hyst_lvl = 7'd0;
  logic wr_en = 1'b0, rd_en = 1'b0, stat_rd = 1'b0;
  logic [7:0] wr_data = 8'd0;
  logic [2:0] wr_err = 3'd0;
  logic [7:0] rd_data;
  logic [2:0] rd_err;
  logic ovr, rx_irq, rts_n, dtr_n, tx_allow;
  logic [CNT_W-1:0] fill;
  logic cts_n = 1'b0, dsr_n = 1'b0, tx_busy = 1'b0;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  rxflow_ctrl dut_i (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .pair_sel(pair_sel),
    .auto_in(auto_in), .auto_out(auto_out), .mcr_rts(mcr_rts), .mcr_dtr(mcr_dtr),
    .trig_lvl(trig_lvl), .hyst_lvl(hyst_lvl),
    .wr_en(wr_en), .wr_data(wr_data), .wr_err(wr_err),
    .rd_en(rd_en), .rd_data(rd_data), .rd_err(rd_err),
    .stat_rd(stat_rd), .ovr(ovr), .fill(fill), .rx_irq(rx_irq),
    .rts_n(rts_n), .dtr_n(dtr_n), .cts_n(cts_n), .dsr_n(dsr_n),
    .tx_busy(tx_busy), .tx_allow(tx_allow)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d, input logic [2:0] e);
    wr_en = 1'b1; wr_data = d; wr_err = e;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pop();
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic drain();
    while (fill != 0) pop();
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R12 fill", fill, 0);
    check("R12 rx_irq", rx_irq, 0);
    check("R12 ovr", ovr, 0);
    check("R12 rts_n", rts_n, 1);
    check("R12 dtr_n", dtr_n, 1);
    check("R12 tx_allow", tx_allow, 1);
  endtask

  task automatic t_order();
    push(8'h3C, 3'd5); push(8'hA1, 3'd0); push(8'h7E, 3'd2);
    check("R2 fill after 3 writes", fill, 3);
    pop(); check("R1 data0", rd_data, 8'h3C); check("R1 err0", rd_err, 5);
    pop(); check("R1 data1", rd_data, 8'hA1); check("R1 err1", rd_err, 0);
    pop(); check("R1 data2", rd_data, 8'h7E); check("R1 err2", rd_err, 2);
    pop(); check("R1 empty read keeps data", rd_data, 8'h7E);
    check("R1 empty read fill", fill, 0);
  endtask

  task automatic t_full();
    int mism = 0;
    for (int i = 0; i < 64; i++) push(8'(i + 16), 3'(i % 8));
    check("R2 fill at capacity", fill, 64);
    check("R4 no overrun yet", ovr, 0);
    push(8'hEE, 3'd7);
    check("R4 fill after dropped write", fill, 64);
    check("R4 overrun set", ovr, 1);
    idle(2);
    check("R4 overrun sticky", ovr, 1);
    stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0;
    check("R4 overrun cleared", ovr, 0);
    for (int i = 0; i < 64; i++) begin
      pop();
      if (rd_data != 8'(i + 16) || rd_err != 3'(i % 8)) mism++;
    end
    check("R4 R1 stored entries intact", mism, 0);
    check("R2 drained", fill, 0);
  endtask

  task automatic t_irq();
    trig_lvl = 7'd4; idle(1);
    push(8'h01, 0); push(8'h02, 0); push(8'h03, 0);
    check("R5 irq below trigger", rx_irq, 0);
    push(8'h04, 0);
    check("R5 irq at trigger", rx_irq, 1);
    pop();
    check("R5 irq after read", rx_irq, 0);
    drain();
    trig_lvl = 7'd0; idle(1);
    push(8'h05, 0);
    check("R5 zero trigger as one", rx_irq, 1);
    drain();
    check("R5 irq clear when empty", rx_irq, 0);
  endtask

  task automatic t_hyst();
    pair_sel = 1'b0; auto_out = 1'b1; mcr_rts = 1'b1; mcr_dtr = 1'b0;
    trig_lvl = 7'd48; hyst_lvl = 7'd8; idle(1);
    check("R6 rts low when empty", rts_n, 0);
    for (int i = 0; i < 55; i++) push(8'(i), 0);
    check("R6 rts low at 55", rts_n, 0);
    push(8'h55, 0);
    check("R6 rts high at 56", rts_n, 1);
    check("R9 dtr follows its bit", dtr_n, 1);
    for (int i = 0; i < 15; i++) pop();
    check("R6 fill 41", fill, 41);
    check("R6 rts still high at 41", rts_n, 1);
    pop();
    check("R6 rts low at 40", rts_n, 0);
    for (int i = 0; i < 16; i++) push(8'(i), 0);
    check("R6 rts high again at 56", rts_n, 1);
    auto_out = 1'b0; idle(1);
    check("R8 manual rts follows bit 1", rts_n, 0);
    mcr_rts = 1'b0; idle(1);
    check("R8 manual rts follows bit 0", rts_n, 1);
    auto_out = 1'b1; drain();
    check("R7 rts high with bit 0 when empty", rts_n, 1);
    mcr_rts = 1'b1; idle(1);
    check("R7 rts low once bit set", rts_n, 0);
  endtask

  task automatic t_pair();
    pair_sel = 1'b1; auto_out = 1'b1; mcr_rts = 1'b1; mcr_dtr = 1'b1;
    trig_lvl = 7'd2; hyst_lvl = 7'd1; idle(1);
    check("R9 dtr low under auto", dtr_n, 0);
    push(8'h11, 0); push(8'h12, 0); push(8'h13, 0);
    check("R9 dtr high at 3", dtr_n, 1);
    check("R9 rts not selected stays low", rts_n, 0);
    pop();
    check("R9 dtr holds at 2", dtr_n, 1);
    pop();
    check("R9 dtr low at 1", dtr_n, 0);
    drain();
    auto_out = 1'b0; mcr_rts = 1'b0; mcr_dtr = 1'b0; pair_sel = 1'b0; idle(1);
  endtask

  task automatic t_nofifo();
    fifo_en = 1'b0; trig_lvl = 7'd10; idle(1);
    push(8'hAA, 3'd1);
    check("R3 fill one", fill, 1);
    check("R3 irq at one entry", rx_irq, 1);
    push(8'hBB, 3'd2);
    check("R3 second write dropped", fill, 1);
    check("R3 R4 overrun", ovr, 1);
    stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0;
    pop();
    check("R3 held data", rd_data, 8'hAA);
    check("R3 held err", rd_err, 1);
    check("R3 irq clears", rx_irq, 0);
    fifo_en = 1'b1; idle(1);
  endtask

  task automatic t_clear();
    auto_in = 1'b1; pair_sel = 1'b0;
    cts_n = 1'b1; idle(4);
    check("R10 cts high blocks", tx_allow, 0);
    cts_n = 1'b0; dsr_n = 1'b1; idle(4);
    check("R10 dsr ignored on rts pair", tx_allow, 1);
    pair_sel = 1'b1; idle(2);
    check("R10 dsr blocks on dtr pair", tx_allow, 0);
    auto_in = 1'b0; idle(2);
    check("R10 gating off", tx_allow, 1);
    auto_in = 1'b1; dsr_n = 1'b0; idle(4);
    check("R10 dsr low allows", tx_allow, 1);
    tx_busy = 1'b1; dsr_n = 1'b1; idle(5);
    check("R11 held while busy", tx_allow, 1);
    tx_busy = 1'b0; idle(2);
    check("R11 applied at boundary", tx_allow, 0);
    dsr_n = 1'b0; auto_in = 1'b0; pair_sel = 1'b0; idle(4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    t_reset();
    t_order();
    t_full();
    t_irq();
    t_hyst();
    t_pair();
    t_nofifo();
    t_clear();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule